// File: doc/BRIEF.md
# NAND Hamming ECC Accumulator

This block sits on the byte data path between a NAND flash device and the rest of the controller. It folds a single-error-correcting Hamming parity over every 256-byte data block as the bytes stream past. The parity is the same whether the page is being programmed or read back. Software or a sequencer pulses a clear before each block and holds the enable high while the block's bytes are transferred. Once the 256th byte has been taken in, the block raises a valid flag. It then presents the 22-bit parity word and the three code bytes in the exact form they are written to the spare area. A later read of the same block yields a new parity that can be compared against the stored code. The error-location and correction logic that uses that comparison is outside this block.

A two-state machine controls the block. In `ST_FILL` it accepts bytes and counts the byte address from 0 to 255. The transition `FILL_TO_DONE` is taken on the edge that accepts the byte at address 255. In `ST_DONE` the result is held and further bytes are ignored. The transition `DONE_TO_FILL` is taken on any edge where the clear is high. A clear seen while in `ST_FILL` takes the transition `FILL_RESTART`, which stays in `ST_FILL` with the count and the parity zeroed.

Top module: `nand_ham_ecc`

## Requirements
- R1: After reset, `code_vld` is 0, `parity_o` is 0, and all three code bytes are 0xFF.
- R2: A byte is taken on a clock edge only when `byte_vld` and `ecc_en` are both 1, `ecc_clr` is 0, and no result is pending. `code_vld` is 0 after 255 taken bytes and becomes 1 right after the edge that takes the 256th byte.
- R3: Column parity sits in `parity_o[5:0]`. For k = 0, 1, 2, bit 2k+1 is the XOR of every data bit whose bit index within its byte has index bit k = 1. Bit 2k is the XOR of every data bit whose index bit k = 0.
- R4: Line parity sits in `parity_o[21:6]`. For a = 0 to 7, bit 6+2a+1 is the XOR of the parities of the bytes whose block address has bit a = 1. Bit 6+2a is the same XOR over the bytes whose address bit a = 0. Block addresses count from 0 in arrival order.
- R5: A byte offered while `ecc_en` is 0 is neither counted nor folded into the parity.
- R6: While `code_vld` is 1 and no clear arrives, further offered bytes are ignored, and `parity_o` and `code_vld` hold their values.
- R7: `ecc_clr` zeroes the parity and the byte count and drops `code_vld` at the next edge. A byte offered in the same cycle as the clear is discarded.
- R8: The stored code word is the low 24 bits of the bitwise complement of `parity_o` shifted left by two. Its two lowest bits are therefore always 1.
- R9: `code_first` carries code bits [23:16], `code_mid` carries bits [15:8], and `code_last` carries bits [7:0]. This is the order in which the bytes are written to the spare area.
- R10: A block of 256 bytes of 0xFF gives a parity of 0 and a code of 0xFF, 0xFF, 0xFF, which matches erased flash.
- R11: Flipping one bit, at block address A and bit index B, changes exactly 11 parity bits. These are column bits 2k+B[k] for k = 0 to 2 and line bits 6+2a+A[a] for a = 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ecc_clr | input | 1 | Clear strobe; restarts the block and has priority over a byte |
| ecc_en | input | 1 | Accumulate enable |
| byte_vld | input | 1 | A data byte is present on `byte_data` this cycle |
| byte_data | input | 8 | Data byte on the NAND path |
| code_vld | output | 1 | 256 bytes have been taken and the result is held |
| parity_o | output | 22 | Line parity [21:6] and column parity [5:0] |
| code_first | output | 8 | First stored code byte (code bits [23:16]) |
| code_mid | output | 8 | Second stored code byte (code bits [15:8]) |
| code_last | output | 8 | Third stored code byte (code bits [7:0]) |

## Verification
Every result is registered exactly once. The parity, the code bytes and `code_vld` therefore all reflect a taken byte or a clear one clock edge after the cycle in which it was offered. The code bytes are a combinational view of the parity register and change together with it.

The bench drives inputs on the falling edge and samples on the following falling edge, half a period after the edge that acts on them. The 255-byte and 256-byte checks land on the two edges around the `FILL_TO_DONE` transition. Checks after a clear, or after ignored bytes, are taken one full cycle after that stimulus and before anything else is offered.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
    localparam int BYTE_W     = 8;
    localparam int IDX_W      = $clog2(BYTE_W);
    localparam int ADDR_W     = 8;
    localparam int BLK_BYTES  = 1 << ADDR_W;
    localparam int COL_W      = 2 * IDX_W;
    localparam int LINE_W     = 2 * ADDR_W;
    localparam int PAR_W      = LINE_W + COL_W;
    localparam int CODE_SHIFT = 2;
    localparam int CODE_W     = PAR_W + CODE_SHIFT;
    localparam int CODE_BYTES = CODE_W / BYTE_W;

    typedef enum logic [0:0] {
        ST_FILL = 1'b0,
        ST_DONE = 1'b1
    } ecc_state_t;

    // bits of a byte whose bit index has index bit k set
    function automatic logic [BYTE_W-1:0] idx_mask(input int k);
        logic [BYTE_W-1:0] m;
        for (int i = 0; i < BYTE_W; i++) m[i] = ((i >> k) & 1) == 1;
        return m;
    endfunction
endpackage

// File: rtl/ecc_col_fold.sv
module ecc_col_fold
    import nand_ecc_pkg::*;
(
    input  logic [BYTE_W-1:0] din,
    output logic [COL_W-1:0]  col,
    output logic              bpar
);
    localparam logic [BYTE_W-1:0] FULL = '1;

    for (genvar k = 0; k < IDX_W; k++) begin : g_col
        localparam logic [BYTE_W-1:0] MSK = idx_mask(k);
        assign col[2*k+1] = ^(din & MSK);
        assign col[2*k]   = ^(din & (FULL ^ MSK));
    end

    assign bpar = ^din;
endmodule

// File: rtl/ecc_line_fold.sv
module ecc_line_fold
    import nand_ecc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              bpar,
    output logic [LINE_W-1:0] line
);
    for (genvar a = 0; a < ADDR_W; a++) begin : g_line
        assign line[2*a+1] = bpar &  addr[a];
        assign line[2*a]   = bpar & ~addr[a];
    end
endmodule

// File: rtl/ecc_code_pack.sv
module ecc_code_pack
    import nand_ecc_pkg::*;
(
    input  logic [PAR_W-1:0]                  parity,
    output logic [CODE_BYTES-1:0][BYTE_W-1:0] bytes_msb_first
);
    logic [CODE_W-1:0] inv_code;

    assign inv_code = ~{parity, {CODE_SHIFT{1'b0}}};

    for (genvar j = 0; j < CODE_BYTES; j++) begin : g_byte
        assign bytes_msb_first[j] = inv_code[CODE_W-1-BYTE_W*j -: BYTE_W];
    end
endmodule

// File: rtl/nand_ham_ecc.sv
module nand_ham_ecc
    import nand_ecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ecc_clr,
    input  logic              ecc_en,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              code_vld,
    output logic [PAR_W-1:0]  parity_o,
    output logic [BYTE_W-1:0] code_first,
    output logic [BYTE_W-1:0] code_mid,
    output logic [BYTE_W-1:0] code_last
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(BLK_BYTES - 1);

    ecc_state_t        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [PAR_W-1:0]  parity_q;
    logic              take;
    logic              take_last;
    logic [COL_W-1:0]  col_c;
    logic [LINE_W-1:0] line_c;
    logic              bpar;
    logic [CODE_BYTES-1:0][BYTE_W-1:0] code_bytes;

    ecc_col_fold  u_col  (.din(byte_data), .col(col_c), .bpar(bpar));
    ecc_line_fold u_line (.addr(addr_q), .bpar(bpar), .line(line_c));
    ecc_code_pack u_pack (.parity(parity_q), .bytes_msb_first(code_bytes));

    assign take      = byte_vld && ecc_en && !ecc_clr && (state_q == ST_FILL);
    assign take_last = take && (addr_q == LAST_ADDR);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: if (take_last) state_d = ST_DONE;   // FILL_TO_DONE
            ST_DONE: if (ecc_clr)   state_d = ST_FILL;   // DONE_TO_FILL
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FILL;
        else        state_q <= state_d;
    end

    // datapath: byte address and parity accumulator
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            parity_q <= '0;
        end else if (ecc_clr) begin
            addr_q   <= '0;
            parity_q <= '0;
        end else if (take) begin
            addr_q   <= addr_q + 1'b1;
            parity_q <= parity_q ^ {line_c, col_c};
        end
    end

    // outputs
    always_comb begin
        code_vld   = (state_q == ST_DONE);
        parity_o   = parity_q;
        code_first = code_bytes[0];
        code_mid   = code_bytes[1];
        code_last  = code_bytes[2];
    end

    // R6
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_vld && !ecc_clr) |=> (code_vld && $stable(parity_o)));

    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_clr |=> (!code_vld && parity_o == '0));

    // R5
    gated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ecc_en && !ecc_clr) |=> $stable(parity_o));

    // R2
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(code_vld) |-> $past(byte_vld && ecc_en && !ecc_clr));

    // R8
    code_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_last[CODE_SHIFT-1:0] == {CODE_SHIFT{1'b1}});
endmodule

// File: tb/nand_ham_ecc_tb.sv
`timescale 1ns/1ps
module nand_ham_ecc_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ecc_clr = 1'b0, ecc_en = 1'b0, byte_vld = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic code_vld;
    logic [21:0] parity_o;
    logic [7:0] code_first, code_mid, code_last;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    logic [7:0] mem [256];

    always #2.5 clk = ~clk;

    nand_ham_ecc u_dut (
        .clk(clk), .rst_n(rst_n), .ecc_clr(ecc_clr), .ecc_en(ecc_en),
        .byte_vld(byte_vld), .byte_data(byte_data), .code_vld(code_vld),
        .parity_o(parity_o), .code_first(code_first), .code_mid(code_mid),
        .code_last(code_last)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int kind, input int a);
        case (kind)
            0: return 8'hFF;
            1: return 8'(a);
            2: return 8'(a * 37 + 5);
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [21:0] ref_par();
        logic [21:0] p = '0;
        for (int a = 0; a < 256; a++) begin
            for (int i = 0; i < 8; i++)
                if (mem[a][i])
                    for (int k = 0; k < 3; k++) p[2*k + ((i >> k) & 1)] ^= 1'b1;
            if (^mem[a])
                for (int b = 0; b < 8; b++) p[6 + 2*b + ((a >> b) & 1)] ^= 1'b1;
        end
        return p;
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_clear();
        ecc_clr = 1'b1; tick(); ecc_clr = 1'b0;
    endtask

    // feed one block; optional single-bit flip and enable gaps with junk bytes
    task automatic feed(input int kind, input int fa, input int fb, input bit gaps);
        for (int a = 0; a < 256; a++) begin
            mem[a] = pat(kind, a);
            if (a == fa) mem[a][fb] = ~mem[a][fb];
            if (gaps && (a % 17 == 3)) begin
                ecc_en = 1'b0; byte_vld = 1'b1; byte_data = 8'h5A; tick();
                ecc_en = 1'b1; byte_vld = 1'b0; byte_data = 8'hC3; tick();
            end
            ecc_en = 1'b1; byte_vld = 1'b1; byte_data = mem[a];
            tick();
            if (a == 254) chk(code_vld == 1'b0, "R2 valid low after 255", 32'(code_vld), 0);
        end
        byte_vld = 1'b0;
    endtask

    task automatic check_result(input string tag);
        logic [21:0] p = ref_par();
        logic [23:0] c = ~{p, 2'b00};
        chk(code_vld == 1'b1, {tag, " R2 valid after 256"}, 32'(code_vld), 1);
        chk(parity_o == p, {tag, " R3 R4 parity"}, 32'(parity_o), 32'(p));
        chk({code_first, code_mid, code_last} == c, {tag, " R8 R9 code bytes"},
            32'({code_first, code_mid, code_last}), 32'(c));
    endtask

    task automatic t_reset();
        chk(code_vld == 1'b0, "R1 valid", 32'(code_vld), 0);
        chk(parity_o == '0, "R1 parity", 32'(parity_o), 0);
        chk({code_first, code_mid, code_last} == 24'hFFFFFF, "R1 code",
            32'({code_first, code_mid, code_last}), 32'hFFFFFF);
    endtask

    task automatic t_erased();
        do_clear(); feed(0, -1, 0, 1'b0);
        check_result("erased");
        chk(parity_o == '0, "R10 parity zero", 32'(parity_o), 0);
        chk({code_first, code_mid, code_last} == 24'hFFFFFF, "R10 code",
            32'({code_first, code_mid, code_last}), 32'hFFFFFF);
    endtask

    task automatic t_patterns();
        do_clear(); feed(1, -1, 0, 1'b0); check_result("ramp");
        do_clear(); feed(3, -1, 0, 1'b0); check_result("zeros");
        do_clear(); feed(3, 77, 2, 1'b0); check_result("onebit");
    endtask

    task automatic t_gaps();
        do_clear(); feed(2, -1, 0, 1'b1); check_result("R5 gaps");
    endtask

    task automatic t_overrun();
        logic [21:0] p;
        do_clear(); feed(1, -1, 0, 1'b0);
        p = parity_o;
        for (int j = 0; j < 5; j++) begin
            ecc_en = 1'b1; byte_vld = 1'b1; byte_data = 8'(j * 3 + 1); tick();
        end
        byte_vld = 1'b0;
        chk(code_vld == 1'b1, "R6 valid holds", 32'(code_vld), 1);
        chk(parity_o == p, "R6 parity holds", 32'(parity_o), 32'(p));
    endtask

    task automatic t_clear();
        ecc_en = 1'b1; byte_vld = 1'b1; byte_data = 8'h01; ecc_clr = 1'b1;
        tick();
        ecc_clr = 1'b0; byte_vld = 1'b0;
        chk(code_vld == 1'b0, "R7 valid cleared", 32'(code_vld), 0);
        chk(parity_o == '0, "R7 parity cleared", 32'(parity_o), 0);
        feed(2, -1, 0, 1'b0); check_result("R7 after clear");
    endtask

    task automatic t_flip();
        logic [21:0] pa, pb, exp_x;
        int fa = 8'hA5, fb = 6;
        do_clear(); feed(2, -1, 0, 1'b0); pa = parity_o;
        do_clear(); feed(2, fa, fb, 1'b0); pb = parity_o;
        exp_x = '0;
        for (int k = 0; k < 3; k++) exp_x[2*k + ((fb >> k) & 1)] = 1'b1;
        for (int b = 0; b < 8; b++) exp_x[6 + 2*b + ((fa >> b) & 1)] = 1'b1;
        chk((pa ^ pb) == exp_x, "R11 flip syndrome", 32'(pa ^ pb), 32'(exp_x));
        chk($countones(pa ^ pb) == 11, "R11 flip count", $countones(pa ^ pb), 11);
    endtask

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_erased();
        t_patterns();
        t_gaps();
        t_overrun();
        t_clear();
        t_flip();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule